// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM of 8192 bytes. The memory has two chip selects, one low-true and one high-true, plus a low-true write strobe and a low-true output strobe. The host offers one access at a time through a request/ready handshake. For each access it supplies an address, write data and a direction flag. A read returns its byte together with a one-cycle valid strobe.

Every memory timing minimum is a nanosecond parameter. Each one becomes a clock-cycle count: it is divided by the clock-period parameter, rounded up, and given a floor of one cycle. The controller then steps through each access with a small state machine and a shared down-counter. It drives the select pair, the write and output strobes, the address, the outgoing data and the enable for the bidirectional data bus. A turnaround guard keeps the controller from driving the bus until the memory has had time to release it after a read.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and right after it, ready is 1, the memory is in standby (low-true select 1, high-true select 0), both strobes are 1, the bus enable is 0 and the response strobe is 0.
- R2: Each timing value T in ns becomes max(1, ceil(T / CLK_PERIOD_NS)) cycles. With the defaults (10 ns clock; 50/35 ns write pulse/data setup; 70/70/45 ns read cycle/access/output enable) the write strobe stays low for 5 cycles and the output strobe for 7.
- R3: A write is one setup cycle (memory selected, bus driven, write strobe 1), then max(pulse, data-setup) cycles with the write strobe 0, then one hold cycle with the bus still driven. The output strobe stays 1 for the whole write and the bus carries the request's data.
- R4: The accepted write spends at least the write-cycle count in setup, pulse, hold and any recovery cycles. Recovery cycles are in standby, and there are as many as are needed to make up that count.
- R5: A read selects the memory with the output strobe 0 for max(read cycle, address access, output enable) cycles. It captures the bus on the last of these cycles and raises the response strobe for exactly the next cycle, with the captured byte.
- R6: A request is accepted only in a cycle where ready is 1. Ready stays 0 from the acceptance until the access, including recovery, has ended. A request presented while ready is 0 has no effect on the address, data or strobes.
- R7: After a read ends, at least ceil(output-disable time) cycles pass with the output strobe 1 and the bus undriven before a write drives the bus. Any missing idle cycles are inserted after the write is accepted, with ready 0 and the memory in standby.
- R8: The bus is never driven while the output strobe is 0. The write strobe is 0 only while the memory is selected, the output strobe is 1 and the bus is driven.
- R9: Whenever ready is 1, the memory is in standby and the bus is undriven.
- R10: The address stays stable for as long as the memory stays selected, and during a selected cycle it equals the accepted request's address (0 and 8191 included).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Low-true asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; a request is taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 13 | Memory address |
| mem_sel_n | output | 1 | Low-true chip select |
| mem_sel | output | 1 | High-true chip select |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output strobe |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Bus drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The bench's memory model returns a poison byte until the read has lasted its full access count. A controller that samples even one cycle early therefore returns 0xEE instead of the stored byte. Writes are issued right after reads with zero to four idle cycles between them. A design that skipped or shortened the turnaround would raise the bus enable while the reference model still expects idle standby cycles. The host keeps a bogus request asserted while the controller is busy. A design that accepted it would change the address or the strobes in mid-access. Writes are landed in the memory model only from the pins, at the rising edge of the write strobe. Data that is dropped before the hold cycle, or an address at the 0 or 8191 boundary that is mangled, therefore shows up on a later read-back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_WREC,
        ST_RACC
    } ctrl_state_e;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          at_zero
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cnt = load_val;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign at_zero = (r_q.cnt == '0);

    // R2: a zero count stays at zero until the next load
    assert_cnt_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (at_zero && !load) |=> at_zero);

endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
    parameter int unsigned OHZ_CYC = 3,
    localparam int unsigned TW = $clog2(OHZ_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_done,
    output logic turn_ok_next
);
    typedef struct packed {
        logic [TW-1:0] left;
    } turn_regs_t;

    turn_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rd_done) begin
            r_d.left = TW'(OHZ_CYC);
        end else if (r_q.left != '0) begin
            r_d.left = r_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // the following cycle has no outstanding turnaround
    assign turn_ok_next = (r_q.left <= TW'(1));

    // R7: right after a read finishes the bus may not be driven next cycle
    assert_turn_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (OHZ_CYC < 2) || !turn_ok_next);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] din,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } cap_regs_t;

    cap_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = cap_en;
        if (cap_en) r_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.valid;
    assign rsp_data  = r_q.data;

    // R5: response strobe lasts one cycle per read
    assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5: the presented byte holds between captures
    assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> $stable(rsp_data));

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_WC_NS       = 70,
    parameter int unsigned T_WP_NS       = 50,
    parameter int unsigned T_DW_NS       = 35,
    parameter int unsigned T_RC_NS       = 70,
    parameter int unsigned T_AA_NS       = 70,
    parameter int unsigned T_OE_NS       = 45,
    parameter int unsigned T_OHZ_NS      = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned WC_CYC    = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned WP_CYC    = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned DS_CYC    = ns_to_cyc(T_DW_NS, CLK_PERIOD_NS);
    localparam int unsigned RC_CYC    = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned AA_CYC    = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
    localparam int unsigned OE_CYC    = ns_to_cyc(T_OE_NS, CLK_PERIOD_NS);
    localparam int unsigned OHZ_CYC   = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
    localparam int unsigned PULSE_CYC = max_u(WP_CYC, DS_CYC);
    localparam int unsigned REC_CYC   = (WC_CYC > PULSE_CYC + 2) ? (WC_CYC - PULSE_CYC - 2) : 0;
    localparam int unsigned RD_CYC    = max_u(RC_CYC, max_u(AA_CYC, OE_CYC));
    localparam int unsigned CNT_MAX   = max_u(max_u(PULSE_CYC, RD_CYC), max_u(REC_CYC, 1));
    localparam int unsigned CW        = $clog2(CNT_MAX + 1);
    localparam int unsigned GW        = $clog2(OHZ_CYC + 1);
    localparam int unsigned REC_LOAD  = (REC_CYC > 0) ? (REC_CYC - 1) : 0;

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_zero;
    logic          cap_en;
    logic          rd_done;
    logic          turn_ok_next;

    sram_phase_cnt #(.CW(CW)) phase_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .at_zero  (cnt_zero)
    );

    sram_turn_guard #(.OHZ_CYC(OHZ_CYC)) turn_guard_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_done      (rd_done),
        .turn_ok_next (turn_ok_next)
    );

    sram_rd_capture #(.DW(DATA_W)) rd_capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .din       (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata)
    );

    // next-state and sequencing
    always_comb begin
        r_d      = r_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cap_en   = 1'b0;
        rd_done  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    if (req_write) begin
                        r_d.state = turn_ok_next ? ST_WSET : ST_TURN;
                    end else begin
                        r_d.state = ST_RACC;
                        cnt_load  = 1'b1;
                        cnt_val   = CW'(RD_CYC - 1);
                    end
                end
            end
            ST_TURN: begin
                if (turn_ok_next) r_d.state = ST_WSET;
            end
            ST_WSET: begin
                r_d.state = ST_WPUL;
                cnt_load  = 1'b1;
                cnt_val   = CW'(PULSE_CYC - 1);
            end
            ST_WPUL: begin
                if (cnt_zero) r_d.state = ST_WHLD;
            end
            ST_WHLD: begin
                if (REC_CYC > 0) begin
                    r_d.state = ST_WREC;
                    cnt_load  = 1'b1;
                    cnt_val   = CW'(REC_LOAD);
                end else begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_WREC: begin
                if (cnt_zero) r_d.state = ST_IDLE;
            end
            ST_RACC: begin
                if (cnt_zero) begin
                    r_d.state = ST_IDLE;
                    cap_en    = 1'b1;
                    rd_done   = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // strobe decode from the registered state
    logic selected;
    always_comb begin
        selected  = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (r_q.state)
            ST_WSET: begin selected = 1'b1; mem_dq_oe = 1'b1; end
            ST_WPUL: begin selected = 1'b1; mem_dq_oe = 1'b1; mem_we_n = 1'b0; end
            ST_WHLD: begin selected = 1'b1; mem_dq_oe = 1'b1; end
            ST_RACC: begin selected = 1'b1; mem_oe_n = 1'b0; end
            default: ;
        endcase
    end

    assign mem_sel_n  = !selected;
    assign mem_sel    = selected;
    assign mem_addr   = r_q.addr;
    assign mem_dq_out = r_q.wdata;
    assign req_ready  = (r_q.state == ST_IDLE);

    // checker: cycles since the output strobe was last low, saturating
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    gap_q <= GW'(OHZ_CYC);
        else if (!mem_oe_n)            gap_q <= '0;
        else if (gap_q < GW'(OHZ_CYC)) gap_q <= gap_q + 1'b1;
    end

    logic sel_act;
    assign sel_act = !mem_sel_n && mem_sel;

    // R8
    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R8
    assert_we_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (sel_act && mem_oe_n && mem_dq_oe));

    // R3: data still driven in the cycle the write strobe rises
    assert_dq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && sel_act));

    // R7
    assert_turn_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (gap_q >= GW'(OHZ_CYC)));

    // R9
    assert_ready_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && !mem_dq_oe && mem_we_n && mem_oe_n));

    // R6
    assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_act && $past(sel_act)) |-> $stable(mem_addr));

    // R5
    assert_rsp_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

endmodule

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb_top;

    localparam int CLKP = 10;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLKP - 1) / CLKP;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_PULSE = imax(cyc(50), cyc(35));
    localparam int E_WC    = cyc(70);
    localparam int E_REC   = (E_WC > E_PULSE + 2) ? E_WC - E_PULSE - 2 : 0;
    localparam int E_RD    = imax(cyc(70), imax(cyc(70), cyc(45)));
    localparam int E_OHZ   = cyc(30);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [12:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    sram_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- memory model on the pins ----------------
    logic [7:0] mem_arr [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] rd_arr(input int a);
        return mem_arr.exists(a) ? mem_arr[a] : 8'h00;
    endfunction
    function automatic logic [7:0] rd_ref(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    // ---------------- reference model ----------------
    // entry bits: {ready, sel, we_n, oe_n, dq_oe, rd_last}
    localparam logic [5:0] E_IDLE = 6'b101100;
    localparam logic [5:0] E_TURN = 6'b001100;
    localparam logic [5:0] E_WSET = 6'b011110;
    localparam logic [5:0] E_WPUL = 6'b010110;
    localparam logic [5:0] E_WHLD = 6'b011110;
    localparam logic [5:0] E_WREC = 6'b001100;
    localparam logic [5:0] E_RACC = 6'b011000;

    logic [5:0] sched [$];
    logic [5:0] cur = E_IDLE;
    logic [12:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    bit          exp_rsp = 0;
    logic [7:0]  exp_rdata = '0;
    int          idle_n = 1000;

    always @(posedge clk) begin
        if (rst_n) begin
            bit prev_last;
            if (cur[5] && req_valid) begin
                m_addr  = req_addr;
                m_wdata = req_wdata;
                if (req_write) begin
                    int extra;
                    extra = (E_OHZ > idle_n) ? E_OHZ - idle_n : 0;
                    for (int i = 0; i < extra; i++) sched.push_back(E_TURN);
                    sched.push_back(E_WSET);
                    for (int i = 0; i < E_PULSE; i++) sched.push_back(E_WPUL);
                    sched.push_back(E_WHLD);
                    for (int i = 0; i < E_REC; i++) sched.push_back(E_WREC);
                    ref_mem[int'(req_addr)] = req_wdata;
                    idle_n = 1000;
                end else begin
                    for (int i = 0; i < E_RD - 1; i++) sched.push_back(E_RACC);
                    sched.push_back(E_RACC | 6'b000001);
                end
            end
            prev_last = cur[0];
            cur = (sched.size() > 0) ? sched.pop_front() : E_IDLE;
            exp_rsp = prev_last;
            if (prev_last) begin
                exp_rdata = rd_ref(int'(m_addr));
                idle_n = 1;
            end else if (cur[5] && idle_n < 1000) begin
                idle_n++;
            end
        end
    end

    // ---------------- pin monitor, memory model, comparison ----------------
    bit we_was_low = 0;
    int rd_age = 0;
    int we_run = 0;
    int oe_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // memory: a write lands when the write strobe rises while selected
            if (we_was_low && mem_we_n && !mem_sel_n && mem_sel)
                mem_arr[int'(mem_addr)] = mem_dq_out;
            we_was_low = !mem_we_n && !mem_sel_n && mem_sel;
            // memory: data only valid once the full access count has elapsed
            if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n) rd_age++;
            else rd_age = 0;
            mem_dq_in <= (rd_age >= E_RD) ? rd_arr(int'(mem_addr)) : 8'hEE;

            // R2: strobe lengths from rounded-up ns values
            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin
                chk(we_run == E_PULSE, "R2", "write strobe low cycles", we_run, E_PULSE);
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin
                chk(oe_run == E_RD, "R2", "output strobe low cycles", oe_run, E_RD);
                oe_run = 0;
            end

            // cycle-by-cycle comparison with the reference model
            chk(req_ready == cur[5], "R4/R6", "req_ready", req_ready, cur[5]);
            chk(mem_sel_n == !cur[4], "R9", "mem_sel_n", mem_sel_n, !cur[4]);
            chk(mem_sel == cur[4], "R9", "mem_sel", mem_sel, cur[4]);
            chk(mem_we_n == cur[3], "R3", "mem_we_n", mem_we_n, cur[3]);
            chk(mem_oe_n == cur[2], "R5", "mem_oe_n", mem_oe_n, cur[2]);
            chk(mem_dq_oe == cur[1], "R7", "mem_dq_oe", mem_dq_oe, cur[1]);
            chk(!(mem_dq_oe && !mem_oe_n), "R8", "bus driven with output strobe low",
                mem_dq_oe, 0);
            chk(rsp_valid == exp_rsp, "R5", "rsp_valid", rsp_valid, exp_rsp);
            if (cur[4])
                chk(mem_addr == m_addr, "R10", "mem_addr", mem_addr, m_addr);
            if (cur[1])
                chk(mem_dq_out == m_wdata, "R3", "mem_dq_out", mem_dq_out, m_wdata);
            if (exp_rsp)
                chk(rsp_rdata == exp_rdata, "R5", "rsp_rdata", rsp_rdata, exp_rdata);
        end
    end

    // ---------------- host driver ----------------
    task automatic issue(input bit w, input logic [12:0] a, input logic [7:0] d,
                         input int gap);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        // R6: bogus request while busy must be ignored
        req_valid = 1'b1;
        req_write = $urandom_range(0, 1);
        req_addr  = 13'($urandom);
        req_wdata = 8'($urandom);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(req_ready && mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
            "R1", "reset outputs", {req_ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid},
            7'b1101100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_sel_n && !mem_sel && !mem_dq_oe && !rsp_valid,
            "R1", "post-reset outputs", {req_ready, mem_sel_n, mem_sel, mem_dq_oe, rsp_valid}, 5'b11000);

        // boundary addresses, R10
        issue(1, 13'h0000, 8'hA5, 0);
        issue(1, 13'h1FFF, 8'h5A, 0);
        issue(0, 13'h0000, 8'h00, 0);
        issue(0, 13'h1FFF, 8'h00, 2);
        // unwritten location reads 0
        issue(0, 13'h0ABC, 8'h00, 1);

        // R7: read then write with 0..4 idle cycles between
        for (int g = 0; g < 5; g++) begin
            issue(0, 13'h0000, 8'h00, g);
            issue(1, 13'(13'h0100 + g), 8'(8'h30 + g), 0);
            issue(0, 13'(13'h0100 + g), 8'h00, 0);
        end

        // back-to-back writes then reads
        for (int i = 0; i < 6; i++) issue(1, 13'(i * 1361), 8'(i * 37 + 1), 0);
        for (int i = 0; i < 6; i++) issue(0, 13'(i * 1361), 8'h00, 0);

        // random mix on a small address window so reads hit written data
        for (int i = 0; i < 120; i++) begin
            issue($urandom_range(0, 1), 13'($urandom_range(0, 15) * 512 + 3),
                  8'($urandom), $urandom_range(0, 3));
        end

        repeat (4) @(negedge clk);
        chk(sched.size() == 0, "R6", "model drained", sched.size(), 0);
        finish_run();
    end

endmodule